// File: doc/BRIEF.md
# Memory-Mapped Register Bank with Fabric Side Ports

This block is an AXI4-Lite slave holding a bank of 64 registers of 32 bits each. A processor on the bus writes registers under byte strobes and reads them back with an OKAY response. Every accepted bus write is also announced to the surrounding user logic as a one-cycle notification carrying the register index and the resulting word.

The user logic has its own full-word write port into the same register array. This lets it post results that the processor later fetches over the bus. When both sides write the same register in one cycle, the user logic's value is kept. The bus clock and reset are passed straight through as outputs so the user logic can run in the same domain.

Top module: `axil_fabric_regfile`

## Requirements
- R1: While `aresetn` is low at a rising edge, all registers clear to zero and `s_bvalid`, `s_rvalid` and `note_vld` go low.
- R2: The register index is address bits [7:2]. Bits [1:0] of `s_awaddr` and `s_araddr` have no effect on which register is selected.
- R3: In a bus write, byte lane k (data bits 8k+7 down to 8k) takes the new data only when `s_wstrb[k]` is 1. Lanes with a 0 strobe keep their old value.
- R4: A write is accepted at a rising edge where `s_awvalid`, `s_wvalid` are high and `s_bvalid` is low. In that cycle `s_awready` and `s_wready` are high. `s_bvalid` is high from the next cycle with `s_bresp` = 2'b00, and it stays high until a rising edge with `s_bready` high.
- R5: A read is accepted at a rising edge where `s_arvalid` is high and `s_rvalid` is low, and `s_arready` equals the inverse of `s_rvalid`. From the next cycle `s_rvalid` is high with `s_rresp` = 2'b00 and `s_rdata` = the register contents before that edge. All three hold until a rising edge with `s_rready` high.
- R6: Without user-side writes, reading an index returns the last word the bus wrote there.
- R7: One cycle after each accepted bus write, `note_vld` is high for exactly one cycle. In that cycle `note_idx` is the written index and `note_data` is the strobe-merged word. `note_vld` never rises without an accepted bus write.
- R8: At a rising edge with `upd_vld` high, register `upd_idx` takes the whole `upd_data` word.
- R9: If a bus write and a user-side write hit the same index at one edge, the register takes `upd_data`. If they hit different indices, both writes take effect.
- R10: `fab_clk` follows `aclk` and `fab_rst_n` follows `aresetn` with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus clock |
| aresetn | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 8 | Write address (byte address) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 8 | Read address (byte address) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| fab_clk | output | 1 | Clock passed through to user logic |
| fab_rst_n | output | 1 | Reset passed through to user logic |
| note_idx | output | 6 | Index of the bus write just accepted |
| note_data | output | 32 | Merged word of that write |
| note_vld | output | 1 | One-cycle write notification |
| upd_idx | input | 6 | User-side write index |
| upd_data | input | 32 | User-side write word |
| upd_vld | input | 1 | User-side write enable |

## Verification
The ready signals are combinational and are due in the same cycle as the valid inputs. The bench checks them one time unit after it drives the inputs on the falling edge. The write response, the notification and the read data all come one register stage after the accepting edge, so they are sampled at the next falling edge. The held response and read data are checked again at the falling edge after that, while ready is still low. Notifications are predicted in a queue when each write is driven and popped by a monitor on every falling edge where `note_vld` is high, which also catches a pulse that lasts two cycles or one with no write behind it.

// File: rtl/axil_fabric_pkg.sv
package axil_fabric_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10
  } resp_e;
endpackage

// File: rtl/regfile_array.sv
module regfile_array #(
  parameter int DATA_W = 32,
  parameter int NREG   = 64,
  localparam int IDX_W  = $clog2(NREG),
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [STRB_W-1:0] bus_wstrb,
  input  logic              upd_vld,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [DATA_W-1:0] upd_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] bus_merged,
  output logic [DATA_W-1:0] rd_word
);

  // Combine old word and new data lane by lane under the strobes.
  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [STRB_W-1:0] strb
  );
    logic [DATA_W-1:0] res;
    res = old_w;
    for (int k = 0; k < STRB_W; k++) begin
      if (strb[k]) res[8*k +: 8] = new_w[8*k +: 8];
    end
    return res;
  endfunction

  logic [DATA_W-1:0] regs [NREG];
  logic [NREG-1:0]   hit_bus;
  logic [NREG-1:0]   hit_upd;

  assign bus_merged = lane_merge(regs[bus_idx], bus_wdata, bus_wstrb);
  assign rd_word    = regs[rd_idx];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign hit_bus[i] = bus_we  && (bus_idx == IDX_W'(i));
    assign hit_upd[i] = upd_vld && (upd_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[i] <= '0;
      end else if (hit_upd[i]) begin
        regs[i] <= upd_data;
      end else if (hit_bus[i]) begin
        regs[i] <= bus_merged;
      end
    end
  end

  AST_ONE_BUS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_bus)); // R2

  AST_FAB_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && bus_we && upd_idx == bus_idx) |=> (regs[$past(upd_idx)] == $past(upd_data))); // R9

  AST_FAB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |=> (regs[$past(upd_idx)] == $past(upd_data))); // R8

endmodule

// File: rtl/axil_wr_ctrl.sv
module axil_wr_ctrl
  import axil_fabric_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 64,
  localparam int IDX_W  = $clog2(NREG),
  localparam int LSB    = $clog2(DATA_W / 8),
  localparam int ADDR_W = IDX_W + LSB
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [DATA_W-1:0] merged,
  output logic              bus_we,
  output logic [IDX_W-1:0]  bus_idx,
  output logic [IDX_W-1:0]  note_idx,
  output logic [DATA_W-1:0] note_data,
  output logic              note_vld
);

  logic bvalid_q;
  logic wr_accept;

  assign wr_accept = s_awvalid && s_wvalid && !bvalid_q;
  assign s_awready = s_wvalid && !bvalid_q;
  assign s_wready  = s_awvalid && !bvalid_q;
  assign bus_we    = wr_accept;
  assign bus_idx   = s_awaddr[ADDR_W-1:LSB];
  assign s_bvalid  = bvalid_q;
  assign s_bresp   = RESP_OKAY;

  always_ff @(posedge aclk) begin
    if (!aresetn) begin
      bvalid_q  <= 1'b0;
      note_vld  <= 1'b0;
      note_idx  <= '0;
      note_data <= '0;
    end else begin
      note_vld <= wr_accept;
      if (wr_accept) begin
        note_idx  <= bus_idx;
        note_data <= merged;
        bvalid_q  <= 1'b1;
      end else if (s_bready) begin
        bvalid_q  <= 1'b0;
      end
    end
  end

  AST_B_HOLD: assert property (@(posedge aclk) disable iff (!aresetn)
    (s_bvalid && !s_bready) |=> s_bvalid); // R4

  AST_B_OKAY: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid |-> (s_bresp == 2'b00)); // R4

  AST_NOTE_PULSE: assert property (@(posedge aclk) disable iff (!aresetn)
    note_vld |=> !note_vld); // R7

  AST_NOTE_CAUSE: assert property (@(posedge aclk) disable iff (!aresetn)
    $rose(note_vld) |-> $past(s_awvalid && s_wvalid)); // R7

endmodule

// File: rtl/axil_rd_ctrl.sv
module axil_rd_ctrl
  import axil_fabric_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 64,
  localparam int IDX_W  = $clog2(NREG),
  localparam int LSB    = $clog2(DATA_W / 8),
  localparam int ADDR_W = IDX_W + LSB
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic [DATA_W-1:0] rd_word,
  output logic [IDX_W-1:0]  rd_idx
);

  logic rvalid_q;
  logic rd_accept;

  assign rd_accept = s_arvalid && !rvalid_q;
  assign s_arready = !rvalid_q;
  assign rd_idx    = s_araddr[ADDR_W-1:LSB];
  assign s_rvalid  = rvalid_q;
  assign s_rresp   = RESP_OKAY;

  always_ff @(posedge aclk) begin
    if (!aresetn) begin
      rvalid_q <= 1'b0;
      s_rdata  <= '0;
    end else if (rd_accept) begin
      rvalid_q <= 1'b1;
      s_rdata  <= rd_word;
    end else if (s_rready) begin
      rvalid_q <= 1'b0;
    end
  end

  AST_R_HOLD: assert property (@(posedge aclk) disable iff (!aresetn)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata))); // R5

  AST_R_OKAY: assert property (@(posedge aclk) disable iff (!aresetn)
    s_rvalid |-> (s_rresp == 2'b00)); // R5

endmodule

// File: rtl/axil_fabric_regfile.sv
module axil_fabric_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 64,
  localparam int IDX_W  = $clog2(NREG),
  localparam int STRB_W = DATA_W / 8,
  localparam int ADDR_W = IDX_W + $clog2(STRB_W)
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              fab_clk,
  output logic              fab_rst_n,
  output logic [IDX_W-1:0]  note_idx,
  output logic [DATA_W-1:0] note_data,
  output logic              note_vld,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [DATA_W-1:0] upd_data,
  input  logic              upd_vld
);

  logic              bus_we;
  logic [IDX_W-1:0]  bus_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] bus_merged;
  logic [DATA_W-1:0] rd_word;

  assign fab_clk   = aclk;
  assign fab_rst_n = aresetn;

  axil_wr_ctrl #(.DATA_W(DATA_W), .NREG(NREG)) u_wr (
    .aclk      (aclk),
    .aresetn   (aresetn),
    .s_awaddr  (s_awaddr),
    .s_awvalid (s_awvalid),
    .s_awready (s_awready),
    .s_wvalid  (s_wvalid),
    .s_wready  (s_wready),
    .s_bresp   (s_bresp),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .merged    (bus_merged),
    .bus_we    (bus_we),
    .bus_idx   (bus_idx),
    .note_idx  (note_idx),
    .note_data (note_data),
    .note_vld  (note_vld)
  );

  axil_rd_ctrl #(.DATA_W(DATA_W), .NREG(NREG)) u_rd (
    .aclk      (aclk),
    .aresetn   (aresetn),
    .s_araddr  (s_araddr),
    .s_arvalid (s_arvalid),
    .s_arready (s_arready),
    .s_rdata   (s_rdata),
    .s_rresp   (s_rresp),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .rd_word   (rd_word),
    .rd_idx    (rd_idx)
  );

  regfile_array #(.DATA_W(DATA_W), .NREG(NREG)) u_array (
    .clk        (aclk),
    .rst_n      (aresetn),
    .bus_we     (bus_we),
    .bus_idx    (bus_idx),
    .bus_wdata  (s_wdata),
    .bus_wstrb  (s_wstrb),
    .upd_vld    (upd_vld),
    .upd_idx    (upd_idx),
    .upd_data   (upd_data),
    .rd_idx     (rd_idx),
    .bus_merged (bus_merged),
    .rd_word    (rd_word)
  );

  AST_RESET_QUIET: assert property (@(posedge aclk)
    !aresetn |=> (!s_bvalid && !s_rvalid && !note_vld)); // R1

endmodule

// File: tb/axil_fabric_regfile_bench.sv
module axil_fabric_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  awaddr = '0;
  logic        awvalid = 1'b0;
  logic        awready;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        wvalid = 1'b0;
  logic        wready;
  logic [1:0]  bresp;
  logic        bvalid;
  logic        bready = 1'b0;
  logic [7:0]  araddr = '0;
  logic        arvalid = 1'b0;
  logic        arready;
  logic [31:0] rdata;
  logic [1:0]  rresp;
  logic        rvalid;
  logic        rready = 1'b0;
  logic        fclk;
  logic        frst_n;
  logic [5:0]  n_idx;
  logic [31:0] n_data;
  logic        n_vld;
  logic [5:0]  u_idx = '0;
  logic [31:0] u_data = '0;
  logic        u_vld = 1'b0;

  always #5 clk = ~clk;

  axil_fabric_regfile u_axil_fabric_regfile (
    .aclk(clk), .aresetn(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .fab_clk(fclk), .fab_rst_n(frst_n),
    .note_idx(n_idx), .note_data(n_data), .note_vld(n_vld),
    .upd_idx(u_idx), .upd_data(u_data), .upd_vld(u_vld)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] mdl [64];
  logic [37:0] note_q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] strobe_apply(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
    logic [31:0] mask;
    mask = {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    return (n & mask) | (o & ~mask);
  endfunction

  // Scoreboard monitor for the write notification (R7)
  always @(negedge clk) begin
    if (rst_n && n_vld) begin
      if (note_q.size() == 0) begin
        chk(1'b0, "R7 unexpected note_vld", {26'd0, n_idx}, 32'd0);
      end else begin
        logic [37:0] e;
        e = note_q.pop_front();
        chk(n_idx == e[37:32], "R7 note_idx", {26'd0, n_idx}, {26'd0, e[37:32]});
        chk(n_data == e[31:0], "R7 note_data", n_data, e[31:0]);
      end
    end
  end

  task automatic finish_bresp();
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0; u_vld = 1'b0;
    chk(bvalid == 1'b1, "R4 bvalid after accept", {31'd0, bvalid}, 32'd1);
    chk(bresp == 2'b00, "R4 bresp okay", {30'd0, bresp}, 32'd0);
    @(negedge clk);
    chk(bvalid == 1'b1, "R4 bvalid held", {31'd0, bvalid}, 32'd1);
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
    chk(bvalid == 1'b0, "R4 bvalid cleared", {31'd0, bvalid}, 32'd0);
  endtask

  task automatic bus_write(input logic [7:0] addr, input logic [31:0] d, input logic [3:0] s);
    logic [5:0] idx;
    logic [31:0] m;
    idx = addr[7:2];
    @(negedge clk);
    awaddr = addr; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
    #1;
    chk(awready && wready, "R4 ready on accept", {31'd0, awready && wready}, 32'd1);
    m = strobe_apply(mdl[idx], d, s);
    note_q.push_back({idx, m});
    mdl[idx] = m;
    finish_bresp();
  endtask

  task automatic collide(input logic [5:0] bidx, input logic [31:0] d, input logic [5:0] fidx, input logic [31:0] fd);
    logic [31:0] m;
    @(negedge clk);
    awaddr = {bidx, 2'b00}; wdata = d; wstrb = 4'hF; awvalid = 1'b1; wvalid = 1'b1;
    u_idx = fidx; u_data = fd; u_vld = 1'b1;
    #1;
    m = strobe_apply(mdl[bidx], d, 4'hF);
    note_q.push_back({bidx, m});
    mdl[bidx] = m;
    mdl[fidx] = fd;
    finish_bresp();
  endtask

  task automatic fab_write(input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk);
    u_idx = idx; u_data = d; u_vld = 1'b1;
    mdl[idx] = d;
    @(negedge clk);
    u_vld = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    araddr = addr; arvalid = 1'b1;
    #1;
    chk(arready == 1'b1, "R5 arready idle", {31'd0, arready}, 32'd1);
    @(negedge clk);
    arvalid = 1'b0;
    chk(rvalid == 1'b1, "R5 rvalid", {31'd0, rvalid}, 32'd1);
    chk(rresp == 2'b00, "R5 rresp okay", {30'd0, rresp}, 32'd0);
    chk(rdata == exp, tag, rdata, exp);
    @(negedge clk);
    chk(rvalid && rdata == exp, "R5 rdata held", rdata, exp);
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
    chk(rvalid == 1'b0, "R5 rvalid cleared", {31'd0, rvalid}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk(frst_n == 1'b0, "R10 reset passthrough low", {31'd0, frst_n}, 32'd0);
    rst_n = 1'b1;
    #1;
    chk(frst_n == 1'b1, "R10 reset passthrough high", {31'd0, frst_n}, 32'd1);
    chk(!bvalid && !rvalid && !n_vld, "R1 outputs idle after reset",
        {29'd0, bvalid, rvalid, n_vld}, 32'd0);
    @(posedge clk); #1;
    chk(fclk == 1'b1, "R10 clock passthrough high", {31'd0, fclk}, 32'd1);
    @(negedge clk); #1;
    chk(fclk == 1'b0, "R10 clock passthrough low", {31'd0, fclk}, 32'd0);
    bus_read(8'h00, 32'h0, "R1 reg0 zero after reset");
    bus_read(8'hFC, 32'h0, "R1 reg63 zero after reset");

    bus_write(8'h00, 32'h12345678, 4'hF);
    bus_read(8'h00, mdl[0], "R6 loopback reg0");
    bus_write(8'hFC, 32'hDEADBEEF, 4'hF);
    bus_read(8'hFC, mdl[63], "R6 loopback reg63");

    bus_write(8'h14, 32'hAAAAAAAA, 4'hF);
    bus_write(8'h14, 32'h55667788, 4'b0101);
    bus_read(8'h14, 32'hAA66AA88, "R3 strobes 0101");
    bus_write(8'h14, 32'h01020304, 4'b0000);
    bus_read(8'h14, 32'hAA66AA88, "R3 no strobes no change");
    bus_write(8'h14, 32'h11223344, 4'b1000);
    bus_read(8'h14, 32'h1166AA88, "R3 top lane only");

    bus_write(8'h13, 32'hCAFEF00D, 4'hF);
    bus_read(8'h11, 32'hCAFEF00D, "R2 low address bits ignored");
    bus_read(8'h10, mdl[4], "R2 aligned read reg4");

    fab_write(6'd7, 32'h0BADC0DE);
    bus_read(8'h1C, 32'h0BADC0DE, "R8 fabric write visible");
    fab_write(6'd0, 32'hFFFF0000);
    bus_read(8'h00, 32'hFFFF0000, "R8 fabric overwrites bus value");

    bus_write(8'h24, 32'h99999999, 4'hF);
    collide(6'd9, 32'h12121212, 6'd9, 32'h34343434);
    bus_read(8'h24, 32'h34343434, "R9 same index fabric wins");
    collide(6'd10, 32'hA5A5A5A5, 6'd11, 32'h5A5A5A5A);
    bus_read(8'h28, 32'hA5A5A5A5, "R9 different index bus part");
    bus_read(8'h2C, 32'h5A5A5A5A, "R9 different index fabric part");

    for (int i = 0; i < 8; i++) begin
      bus_write(8'(((i * 7 + 20) % 64) * 4), 32'h1000_0001 * (i + 3), 4'hF);
    end
    for (int i = 0; i < 8; i++) begin
      bus_read(8'(((i * 7 + 20) % 64) * 4), mdl[(i * 7 + 20) % 64], "R6 loopback sweep");
    end

    repeat (3) @(negedge clk);
    chk(note_q.size() == 0, "R7 all notifications seen", note_q.size(), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule